// File: doc/BRIEF.md
# Seven-Level Inverter Gate Pattern Generator

This block drives the ten power switches of a single-phase seven-level inverter. The inverter stacks three equal DC sources through three cascade legs and then reverses polarity with a full bridge. Each clock, the block works out a rectified reference from a free-running phase accumulator at the reference frequency. It compares that reference with three stacked, sinusoid-shaped carriers that share one carrier phase. The number of carriers the reference lies above gives the level magnitude, from 0 to 3. The half of the reference period sets the sign. A fixed leg pattern and a bridge direction then turn the signed level into gate bits.

Two reference shapes are offered. The plain sine shape accepts modulation indices up to 1. The space-vector shape subtracts the mid-point of three sines spaced 120 degrees apart, rescales the result to unit peak, and limits the index to 0.866. The modulation index is an unsigned word, where 1024 stands for 1.0. A low enable holds the output at level 0 while the phase keeps running.

Top module: `inv7_gate_gen`

## Requirements
- R1: While reset is held, level_o is 0 and gate_o is 10'h0D5.
- R2: Bit gate_o[n-1] drives switch n. The on-switches among 1..6, by level magnitude, are: magnitude 0 gives 1,3,5; magnitude 1 gives 1,3,6; magnitude 2 gives 1,4,6; magnitude 3 gives 2,4,6.
- R3: Switches 7 and 8 (gate_o[7:6]) are on and switches 9 and 10 (gate_o[9:8]) are off for level 0 and for positive levels. Negative levels reverse this.
- R4: The switch pairs (1,2), (3,4), (5,6), (7,9) and (8,10) are never on together.
- R5: With M = mod_i/1024 in sine mode, the largest magnitude over one reference period depends on M as follows. It is 0 when M is 0, 1 when 3M < 1, 2 when 1 < 3M < 2, and 3 when 3M > 2. The most negative level mirrors the largest positive one.
- R6: In sine mode, any mod_i above 1024 acts exactly as 1024.
- R7: In space-vector mode, any mod_i above 887 acts exactly as 887, and 887 still reaches magnitude 3.
- R8: At the same mod_i, the space-vector mode gives a larger sum of level magnitudes over one period than sine mode.
- R9: Counting from reset, where the phase is zero, levels are never negative in the first half of each reference period and never positive in the second half. A period is CLK_HZ/REF_HZ clocks.
- R10: From the first clock edge after en_i falls, level_o is 0 and gate_o is 10'h0D5. Modulation resumes at the running phase when en_i rises again.
- R11: While en_i, sv_mode_i and mod_i are held, the level magnitude changes by at most one step per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Modulation enable; low forces level 0 |
| sv_mode_i | input | 1 | 1 selects the space-vector reference, 0 the sine reference |
| mod_i | input | MOD_W (11) | Modulation index, 1024 = 1.0 |
| gate_o | output | 10 | Gate bits, bit n-1 drives switch n |
| level_o | output | 3 | Current level, signed, -3 to +3 |

## Verification
An enable drop and the reference zero crossing can reach the level register on the same clock edge. The clear of the magnitude then races the flip of the polarity flag. The bench lowers en_i so that the first edge with enable low is also the edge that takes in the crossed phase. It then requires level 0 together with the positive-bridge pattern 10'h0D5, not a negative zero with switches 9 and 10 on. After enable returns, negative levels must appear again in the same half period.

// File: rtl/inv7_pkg.sv
package inv7_pkg;
  localparam int AMP_W      = 12;            // carrier / |sine| amplitude bits
  localparam int PH_W       = AMP_W + 1;     // phase bits: half flag + position
  localparam int BANDS      = 3;             // cascade legs / carrier bands
  localparam int MAG_W      = $clog2(BANDS + 1);
  localparam int REF_W      = AMP_W + $clog2(BANDS + 1);
  localparam int MOD_ONE    = 1024;
  localparam int MOD_FRAC   = $clog2(MOD_ONE);
  localparam int MOD_SV_MAX = 887;           // 0.866 * 1024
  localparam int SV_GAIN    = 2365;          // 2/sqrt(3) in Q11
  localparam int SV_SHIFT   = 11;

  typedef logic signed [2:0] level_t;

  // Parabolic half-wave: x spans half a period, peak saturates at full scale
  function automatic logic [AMP_W-1:0] half_sine(input logic [AMP_W-1:0] x);
    logic [AMP_W:0]     xc;
    logic [2*AMP_W-1:0] p;
    logic [2*AMP_W-1:0] q;
    xc = (AMP_W+1)'(1 << AMP_W) - {1'b0, x};
    p  = (2*AMP_W)'(x) * (2*AMP_W)'(xc);
    q  = p >> (AMP_W - 2);
    return (q > (2*AMP_W)'((1 << AMP_W) - 1)) ? AMP_W'((1 << AMP_W) - 1) : q[AMP_W-1:0];
  endfunction
endpackage

// File: rtl/inv7_nco.sv
module inv7_nco
  import inv7_pkg::*;
#(
  parameter int               ACC_W = 32,
  parameter logic [ACC_W-1:0] INC   = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [PH_W-1:0] phase_o
);
  logic [ACC_W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_q + INC;
  end

  assign phase_o = PH_W'(acc_q >> (ACC_W - PH_W));
endmodule

// File: rtl/inv7_ref_shaper.sv
module inv7_ref_shaper
  import inv7_pkg::*;
#(
  parameter int MOD_W = 11
) (
  input  logic [PH_W-1:0]  phase_i,
  input  logic             sv_mode_i,
  input  logic [MOD_W-1:0] mod_i,
  output logic [REF_W-1:0] ref_o,
  output logic             neg_o
);
  localparam logic [PH_W-1:0] THIRD = PH_W'((1 << PH_W) / 3);
  localparam int              SW    = AMP_W + 2;
  localparam int              PW    = SW + 13;

  function automatic logic signed [AMP_W:0] ssine(input logic [PH_W-1:0] p);
    logic signed [AMP_W:0] m;
    m = $signed({1'b0, half_sine(p[PH_W-2:0])});
    return p[PH_W-1] ? -m : m;
  endfunction

  logic signed [AMP_W:0] s [BANDS];

  // three sines spaced one third of a period apart
  for (genvar k = 0; k < BANDS; k++) begin : g_ph
    assign s[k] = ssine(phase_i + PH_W'(k) * THIRD);
  end

  logic signed [AMP_W:0] mx, mn;
  logic signed [SW-1:0]  cm, v;
  logic signed [PW-1:0]  vp, vs;
  logic [AMP_W-1:0]      sv_mag, sin_mag, mag;
  logic [MOD_W-1:0]      lim, mod_eff;

  always_comb begin
    mx = s[0];
    mn = s[0];
    for (int k = 1; k < BANDS; k++) begin
      if (s[k] > mx) mx = s[k];
      if (s[k] < mn) mn = s[k];
    end
    cm = (SW'(mx) + SW'(mn)) >>> 1;
    v  = SW'(s[0]) - cm;
    vp = PW'(v) * PW'(SV_GAIN);
    vs = vp >>> SV_SHIFT;
    if (vs < 0) vs = -vs;
    sv_mag  = (vs > PW'((1 << AMP_W) - 1)) ? AMP_W'((1 << AMP_W) - 1) : AMP_W'(vs);
    sin_mag = half_sine(phase_i[PH_W-2:0]);
    mag     = sv_mode_i ? sv_mag : sin_mag;
    lim     = sv_mode_i ? MOD_W'(MOD_SV_MAX) : MOD_W'(MOD_ONE);
    mod_eff = (mod_i > lim) ? lim : mod_i;
  end

  assign ref_o = REF_W'(((AMP_W+MOD_W+2)'(mag) * (AMP_W+MOD_W+2)'(mod_eff)
                         * (AMP_W+MOD_W+2)'(BANDS)) >> MOD_FRAC);
  assign neg_o = phase_i[PH_W-1];
endmodule

// File: rtl/inv7_level_cmp.sv
module inv7_level_cmp
  import inv7_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             sv_mode_i,
  input  logic [10:0]      mod_i,
  input  logic [REF_W-1:0] ref_i,
  input  logic             neg_i,
  input  logic [PH_W-1:0]  car_phase_i,
  output level_t           level_o
);
  localparam int HALF = 1 << (AMP_W - 1);

  logic [AMP_W-1:0] hc, car;
  logic [BANDS-1:0] hit;
  logic [MAG_W-1:0] cnt, mag_q;
  logic             neg_q;

  // raised sinusoid spanning one band, 0 .. full scale
  assign hc  = half_sine(car_phase_i[PH_W-2:0]);
  assign car = car_phase_i[PH_W-1] ? AMP_W'(HALF - 1) - (hc >> 1)
                                   : AMP_W'(HALF) + (hc >> 1);

  for (genvar k = 0; k < BANDS; k++) begin : g_band
    assign hit[k] = ref_i > ((REF_W'(k) << AMP_W) + REF_W'(car));
  end

  always_comb begin
    cnt = '0;
    for (int k = 0; k < BANDS; k++) cnt = cnt + MAG_W'(hit[k]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mag_q <= '0;
      neg_q <= 1'b0;
    end else begin
      mag_q <= en_i ? cnt : '0;
      neg_q <= neg_i;
    end
  end

  assign level_o = neg_q ? -$signed({1'b0, mag_q}) : $signed({1'b0, mag_q});

  AST_EN_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (level_o == 3'sd0)); // R10
  AST_MAG_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && $stable(mod_i) && $stable(sv_mode_i)) |=>
    (((mag_q >= $past(mag_q)) ? (mag_q - $past(mag_q)) : ($past(mag_q) - mag_q)) <= MAG_W'(1))); // R11
endmodule

// File: rtl/inv7_gate_map.sv
module inv7_gate_map
  import inv7_pkg::*;
(
  input  level_t      level_i,
  output logic [9:0]  gate_o
);
  level_t           lm;
  logic [MAG_W-1:0] mag;
  logic             neg;

  assign neg = level_i[2];
  assign lm  = neg ? -level_i : level_i;
  assign mag = MAG_W'(lm);

  // leg k inserts its source once magnitude reaches BANDS-k
  for (genvar k = 0; k < BANDS; k++) begin : g_leg
    logic ins;
    assign ins          = mag >= MAG_W'(BANDS - k);
    assign gate_o[2*k+1] = ins;
    assign gate_o[2*k]   = ~ins;
  end

  assign gate_o[7:6] = {2{~neg}};
  assign gate_o[9:8] = {2{neg}};
endmodule

// File: rtl/inv7_gate_gen.sv
module inv7_gate_gen
  import inv7_pkg::*;
#(
  parameter int CLK_HZ = 125_000_000,
  parameter int REF_HZ = 50,
  parameter int CAR_HZ = 5_000,
  parameter int ACC_W  = 32,
  parameter int MOD_W  = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             sv_mode_i,
  input  logic [MOD_W-1:0] mod_i,
  output logic [9:0]       gate_o,
  output logic signed [2:0] level_o
);
  localparam logic [ACC_W-1:0] REF_INC = ACC_W'((64'(REF_HZ) << ACC_W) / 64'(CLK_HZ));
  localparam logic [ACC_W-1:0] CAR_INC = ACC_W'((64'(CAR_HZ) << ACC_W) / 64'(CLK_HZ));

  logic [PH_W-1:0]  ref_ph, car_ph;
  logic [REF_W-1:0] ref_val;
  logic             ref_neg;
  level_t           lvl;

  inv7_nco #(.ACC_W(ACC_W), .INC(REF_INC)) u_ref_nco (
    .clk_i(clk_i), .rst_ni(rst_ni), .phase_o(ref_ph));

  inv7_nco #(.ACC_W(ACC_W), .INC(CAR_INC)) u_car_nco (
    .clk_i(clk_i), .rst_ni(rst_ni), .phase_o(car_ph));

  inv7_ref_shaper #(.MOD_W(MOD_W)) u_shaper (
    .phase_i(ref_ph), .sv_mode_i(sv_mode_i), .mod_i(mod_i),
    .ref_o(ref_val), .neg_o(ref_neg));

  inv7_level_cmp u_cmp (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .sv_mode_i(sv_mode_i),
    .mod_i(11'(mod_i)), .ref_i(ref_val), .neg_i(ref_neg),
    .car_phase_i(car_ph), .level_o(lvl));

  inv7_gate_map u_map (.level_i(lvl), .gate_o(gate_o));

  assign level_o = lvl;

  AST_LEG_COMPL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_o[0] ^ gate_o[1]) && (gate_o[2] ^ gate_o[3]) && (gate_o[4] ^ gate_o[5]) &&
    (gate_o[6] ^ gate_o[8]) && (gate_o[7] ^ gate_o[9])); // R4
  AST_BRIDGE_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_o[9] == (level_o < 3'sd0)); // R3
endmodule

// File: tb/tb_inv7_gate_gen.sv
module tb_inv7_gate_gen;
  localparam int CLK_HZ = 500_000;
  localparam int PER    = CLK_HZ / 50;
  localparam int HALF   = PER / 2;

  typedef struct {
    int pk, mn, sm, badleg, badbr, badpair, negfirst, possec, bigstep;
  } run_t;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n = 1'b0, en = 1'b0, sv = 1'b0;
  logic [10:0]       mod = '0;
  logic [9:0]        gate;
  logic signed [2:0] lvl;
  int checks = 0, failures = 0;
  int sum_sine614 = 0;

  inv7_gate_gen #(.CLK_HZ(CLK_HZ)) dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .sv_mode_i(sv), .mod_i(mod),
    .gate_o(gate), .level_o(lvl));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] exp_gate(input int l);
    int m = (l < 0) ? -l : l;
    logic [5:0] leg;
    case (m)
      0:       leg = 6'b010101;
      1:       leg = 6'b100101;
      2:       leg = 6'b101001;
      default: leg = 6'b101010;
    endcase
    return {(l < 0) ? 4'b1100 : 4'b0011, leg};
  endfunction

  task automatic do_reset(input bit e, input bit s, input int m);
    en = e; sv = s; mod = 11'(m);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_period(input bit e, input bit s, input int m, output run_t r);
    int prev = 0;
    r = '{default: 0};
    do_reset(e, s, m);
    for (int i = 0; i < PER; i++) begin
      int l, al, ap;
      logic [9:0] g, x;
      @(negedge clk);
      l = int'(lvl);
      g = gate;
      x = exp_gate(l);
      if (g[5:0] != x[5:0]) r.badleg++;
      if (g[9:6] != x[9:6]) r.badbr++;
      if ((g[0] & g[1]) | (g[2] & g[3]) | (g[4] & g[5]) | (g[6] & g[8]) | (g[7] & g[9]))
        r.badpair++;
      if (l > r.pk) r.pk = l;
      if (l < r.mn) r.mn = l;
      al = (l < 0) ? -l : l;
      ap = (prev < 0) ? -prev : prev;
      r.sm += al;
      if (i >= 5 && i < HALF - 10 && l < 0) r.negfirst++;
      if (i >= HALF + 10 && i < PER - 10 && l > 0) r.possec++;
      if (al - ap > 1 || ap - al > 1) r.bigstep++;
      prev = l;
    end
  endtask

  task automatic common(input run_t r);
    chk(r.badleg == 0, "R2 leg pattern mismatches", r.badleg, 0);
    chk(r.badbr == 0, "R3 bridge pattern mismatches", r.badbr, 0);
    chk(r.badpair == 0, "R4 complementary pair overlaps", r.badpair, 0);
    chk(r.bigstep == 0, "R11 magnitude jumps", r.bigstep, 0);
  endtask

  task automatic t_reset();
    en = 1'b1; mod = 11'd1024; sv = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(lvl == 3'sd0, "R1 level in reset", int'(lvl), 0);
    chk(gate == 10'h0D5, "R1 gates in reset", int'(gate), 'h0D5);
  endtask

  task automatic t_sine_peaks();
    int mods [4] = '{0, 307, 614, 922};
    int pks  [4] = '{0, 1, 2, 3};
    for (int k = 0; k < 4; k++) begin
      run_t r;
      run_period(1'b1, 1'b0, mods[k], r);
      common(r);
      chk(r.pk == pks[k], "R5 positive peak", r.pk, pks[k]);
      chk(r.mn == -pks[k], "R5 negative peak", r.mn, -pks[k]);
      chk(r.negfirst == 0, "R9 negative in first half", r.negfirst, 0);
      chk(r.possec == 0, "R9 positive in second half", r.possec, 0);
      if (mods[k] == 614) sum_sine614 = r.sm;
    end
  endtask

  task automatic t_sine_clamp();
    run_t a, b;
    run_period(1'b1, 1'b0, 1024, a);
    run_period(1'b1, 1'b0, 2047, b);
    common(b);
    chk(a.sm == b.sm, "R6 clamp at 1024", b.sm, a.sm);
    chk(b.pk == 3, "R6 peak above full scale", b.pk, 3);
  endtask

  task automatic t_sv();
    run_t a, b, c;
    run_period(1'b1, 1'b1, 887, a);
    run_period(1'b1, 1'b1, 1024, b);
    common(b);
    chk(a.sm == b.sm, "R7 clamp at 887", b.sm, a.sm);
    chk(a.pk == 3, "R7 peak at 887", a.pk, 3);
    run_period(1'b1, 1'b1, 614, c);
    common(c);
    chk(c.sm > sum_sine614, "R8 space-vector sum vs sine", c.sm, sum_sine614 + 1);
    chk(c.negfirst == 0 && c.possec == 0, "R9 space-vector polarity",
        c.negfirst + c.possec, 0);
  endtask

  task automatic t_enable_off();
    run_t r;
    run_period(1'b0, 1'b0, 1024, r);
    chk(r.pk == 0 && r.mn == 0, "R10 disabled level range", r.pk - r.mn, 0);
    chk(r.badleg == 0 && r.badbr == 0, "R10 disabled gates", r.badleg + r.badbr, 0);
  endtask

  // enable drop lands on the edge that takes in the crossed phase
  task automatic t_enable_crossing();
    int bad = 0, mn = 0;
    do_reset(1'b1, 1'b0, 1024);
    for (int i = 0; i <= HALF; i++) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(lvl == 3'sd0, "R10 level at crossing", int'(lvl), 0);
    chk(gate == 10'h0D5, "R10 gates at crossing", int'(gate), 'h0D5);
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (lvl != 3'sd0 || gate != 10'h0D5) bad++;
    end
    chk(bad == 0, "R10 held while disabled", bad, 0);
    en = 1'b1;
    for (int i = HALF + 52; i < PER - 100; i++) begin
      @(negedge clk);
      if (int'(lvl) < mn) mn = int'(lvl);
    end
    chk(mn == -3, "R9 negative half after re-enable", mn, -3);
  endtask

  initial begin
    repeat (180_000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_sine_peaks();
    t_sine_clamp();
    t_sv();
    t_enable_off();
    t_enable_crossing();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule